// File: doc/BRIEF.md
# Interrupt Line Routing Engine

This block watches a set of interrupt request lines and decides, for each line, when an interrupt message must go to the processors. The per-line settings (vector, delivery mode, destination mode, trigger type, mask and a 32-bit destination word) come in as flat input buses from a table that lives outside the block. The block keeps its own state for each line: the last sampled level, a pending flag, a remote-lockout flag for level-triggered lines, and a delivery-status flag. It shows the last three on output buses so that the table logic can return them on reads.

A line rising from low to high records a pending request. A per-line configuration pulse or a matching end-of-interrupt notice asks for a new evaluation. Lines that need evaluation are served one at a time, lowest index first. Each evaluation can place one message in an output register. That register presents vector, mode, trigger type, destination byte and destination mode on a valid/ready interface and holds them until they are accepted. Level-triggered lines stay locked out after a delivery until an end-of-interrupt with their vector arrives. While the lockout is set, a re-evaluation sends nothing.

Top module: `irq_route_engine`

## Requirements
- R1: A line acts only on a low-to-high change of its sampled level. A line that stays high produces no further request and no further message.
- R2: A rising line whose entry is edge-triggered (level flag 0) and masked (mask flag 1) is discarded. Its pending flag stays 0, and unmasking it later with a configuration pulse sends nothing.
- R3: A rising line whose entry is level-triggered and masked sets its pending flag and its delivery-status flag. No message is sent while the mask is set.
- R4: Evaluating a pending, unmasked, edge-triggered entry clears its pending flag and sends one message. After reset no message is valid and all per-line flags are 0.
- R5: Evaluating a pending, unmasked, level-triggered entry sets its remote-lockout flag. If that flag was already 1 before the evaluation, no message is sent.
- R6: When a line falls, its sampled level clears. For a level-triggered entry its pending flag also clears.
- R7: An end-of-interrupt notice clears the remote-lockout flag of every entry whose vector equals the notice's vector and whose lockout is set, and it re-evaluates those entries. A notice with any other vector changes nothing.
- R8: Only delivery mode 0 (fixed) and mode 1 (lowest priority) produce a message. An evaluation in any other mode sends nothing, and it still applies the R4/R5 flag updates and clears delivery status.
- R9: The message destination equals bits 31:24 of the entry's destination word. The message also carries the entry's vector, mode, level flag and destination-mode bit.
- R10: When several entries need evaluation, the lowest-numbered entry is served first.
- R11: A valid message keeps all its fields unchanged until ready is high at a clock edge.
- R12: A configuration pulse for an entry causes a new evaluation of that entry under the same rules as a new request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | NUM_LINES | Interrupt request lines |
| cfg_vector | input | NUM_LINES*8 | Vector per entry, entry i in bits [8i+7:8i] |
| cfg_mode | input | NUM_LINES*3 | Delivery mode per entry, entry i in bits [3i+2:3i] |
| cfg_dest_logical | input | NUM_LINES | Destination-mode bit per entry |
| cfg_level | input | NUM_LINES | 1 = level-triggered, 0 = edge-triggered |
| cfg_mask | input | NUM_LINES | 1 = entry masked |
| cfg_dest_word | input | NUM_LINES*DWORD_W | Destination word per entry |
| cfg_wr | input | NUM_LINES | Per-entry configuration-write pulse |
| eoi_valid | input | 1 | End-of-interrupt notice strobe |
| eoi_vector | input | 8 | Vector carried by the notice |
| msg_valid | output | 1 | Message valid |
| msg_ready | input | 1 | Downstream accepts message |
| msg_vector | output | 8 | Message vector |
| msg_mode | output | 3 | Message delivery mode |
| msg_level | output | 1 | Message trigger type (1 = level) |
| msg_dest | output | 8 | Message destination byte |
| msg_dest_logical | output | 1 | Message destination mode |
| pend_o | output | NUM_LINES | Pending flag per entry |
| rirr_o | output | NUM_LINES | Remote-lockout flag per entry |
| dstat_o | output | NUM_LINES | Delivery-status flag per entry |

## Verification
On every cycle the assertions check several properties. A held message stays stable, and a message is never overwritten. The chosen entry is unique. Only modes 0 and 1 reach the output. A falling level line drops its pending flag, and a masked edge is never recorded. A matching end-of-interrupt always releases the lockout. Only the directed scenarios can show the sequences that play out over time. These include the single message for a line held high, lockout and release across an end-of-interrupt, delivery after unmasking, the order of service, and the exact field values in each message.

// File: rtl/irq_route_pkg.sv
// Shared widths, delivery-mode codes and message type for the routing engine.
// Assumes an 8-bit vector, a 3-bit delivery mode and an 8-bit destination byte.
package irq_route_pkg;
    localparam int VEC_W  = 8;
    localparam int MODE_W = 3;
    localparam int DEST_W = 8;

    localparam logic [MODE_W-1:0] MODE_FIXED  = 3'd0;
    localparam logic [MODE_W-1:0] MODE_LOWPRI = 3'd1;

    typedef struct packed {
        logic [VEC_W-1:0]  vector;
        logic [MODE_W-1:0] mode;
        logic              level;
        logic [DEST_W-1:0] dest;
        logic              dest_logical;
    } route_msg_t;
endpackage

// File: rtl/irq_edge_track.sv
// Samples each request line once per cycle and flags low-to-high and
// high-to-low changes against the sampled level.
// Assumes the lines are already synchronous to clk.
module irq_edge_track #(
    parameter int NUM_LINES = 24
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] line_in,
    output logic [NUM_LINES-1:0] level_q,
    output logic [NUM_LINES-1:0] rise,
    output logic [NUM_LINES-1:0] fall
);
    // Remember the level seen on the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) level_q <= '0;
        else        level_q <= line_in;
    end

    // Changes against the remembered level.
    assign rise = line_in & ~level_q;
    assign fall = ~line_in & level_q;
endmodule

// File: rtl/irq_prio_pick.sv
// Fixed-priority picker: grants the lowest-numbered requester.
// Assumes requests are stable for the cycle; purely combinational.
module irq_prio_pick #(
    parameter int NUM_LINES = 24,
    localparam int IDX_W    = $clog2(NUM_LINES)
) (
    input  logic [NUM_LINES-1:0] req,
    output logic [NUM_LINES-1:0] grant,
    output logic [IDX_W-1:0]     idx,
    output logic                 any
);
    logic [NUM_LINES-1:0] below;

    assign below[0] = 1'b0;
    for (genvar g = 1; g < NUM_LINES; g++) begin : g_chain
        assign below[g] = below[g-1] | req[g-1];
    end

    assign grant = req & ~below;
    assign any   = |req;

    // Encode the index of the lowest requester.
    always_comb begin
        idx = '0;
        for (int i = NUM_LINES - 1; i >= 0; i--) begin
            if (req[i]) idx = IDX_W'(i);
        end
    end

    // R10: at most one grant, and it matches the encoded index.
    always_comb begin
        p_grant_onehot_r10: assert ($onehot0(grant));
        if (any) p_grant_idx_r10: assert (grant[idx]);
    end
endmodule

// File: rtl/irq_msg_slot.sv
// One-entry output register on a valid/ready interface.
// Assumes load is only raised while the slot is empty.
module irq_msg_slot
    import irq_route_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  route_msg_t load_msg,
    input  logic       ready,
    output logic       valid,
    output route_msg_t msg
);
    // Fill on load, empty on handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
            msg   <= '0;
        end else if (load) begin
            valid <= 1'b1;
            msg   <= load_msg;
        end else if (valid && ready) begin
            valid <= 1'b0;
        end
    end

    // R11: a waiting message keeps its content.
    p_hold_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
        valid && !ready |=> valid && $stable(msg));

    // R11: the slot is never overwritten.
    p_no_overwrite_r11: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !valid);
endmodule

// File: rtl/irq_route_engine.sv
// Routing engine: records requests per line, evaluates one entry per cycle in
// ascending order when the output slot is empty, applies edge/level and
// remote-lockout rules, and issues messages. Entry settings come from outside.
// Assumes all inputs are synchronous to clk.
module irq_route_engine
    import irq_route_pkg::*;
#(
    parameter int NUM_LINES = 24,
    parameter int DWORD_W   = 32,
    localparam int IDX_W    = $clog2(NUM_LINES),
    localparam int DEST_LSB = DWORD_W - DEST_W
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_LINES-1:0]         irq_in,
    input  logic [NUM_LINES*VEC_W-1:0]   cfg_vector,
    input  logic [NUM_LINES*MODE_W-1:0]  cfg_mode,
    input  logic [NUM_LINES-1:0]         cfg_dest_logical,
    input  logic [NUM_LINES-1:0]         cfg_level,
    input  logic [NUM_LINES-1:0]         cfg_mask,
    input  logic [NUM_LINES*DWORD_W-1:0] cfg_dest_word,
    input  logic [NUM_LINES-1:0]         cfg_wr,
    input  logic                         eoi_valid,
    input  logic [VEC_W-1:0]             eoi_vector,
    output logic                         msg_valid,
    input  logic                         msg_ready,
    output logic [VEC_W-1:0]             msg_vector,
    output logic [MODE_W-1:0]            msg_mode,
    output logic                         msg_level,
    output logic [DEST_W-1:0]            msg_dest,
    output logic                         msg_dest_logical,
    output logic [NUM_LINES-1:0]         pend_o,
    output logic [NUM_LINES-1:0]         rirr_o,
    output logic [NUM_LINES-1:0]         dstat_o
);
    logic [NUM_LINES-1:0] level_q, rise, fall;
    logic [NUM_LINES-1:0] need_q, pend_q, rirr_q, dstat_q;
    logic [NUM_LINES-1:0] need_d, pend_d, rirr_d, dstat_d;
    logic [NUM_LINES-1:0] grant;
    logic [IDX_W-1:0]     sel;
    logic                 any_need, do_eval, active, send;
    route_msg_t           new_msg, out_msg;

    irq_edge_track #(.NUM_LINES(NUM_LINES)) i_track (
        .clk(clk), .rst_n(rst_n), .line_in(irq_in),
        .level_q(level_q), .rise(rise), .fall(fall)
    );

    irq_prio_pick #(.NUM_LINES(NUM_LINES)) i_pick (
        .req(need_q), .grant(grant), .idx(sel), .any(any_need)
    );

    // Gather the selected entry's settings and decide whether to send.
    always_comb begin
        int si;
        si = int'(sel);
        do_eval = any_need && !msg_valid;
        active  = do_eval && pend_q[si] && !cfg_mask[si];
        new_msg.vector       = cfg_vector[si*VEC_W +: VEC_W];
        new_msg.mode         = cfg_mode[si*MODE_W +: MODE_W];
        new_msg.level        = cfg_level[si];
        new_msg.dest         = cfg_dest_word[si*DWORD_W + DEST_LSB +: DEST_W];
        new_msg.dest_logical = cfg_dest_logical[si];
        send = active
            && (new_msg.mode == MODE_FIXED || new_msg.mode == MODE_LOWPRI)
            && (!cfg_level[si] || !rirr_q[si]);
    end

    // Per-line next state: evaluation, new request, config pulse, EOI, fall.
    always_comb begin
        need_d  = need_q;
        pend_d  = pend_q;
        rirr_d  = rirr_q;
        dstat_d = dstat_q;
        for (int i = 0; i < NUM_LINES; i++) begin
            if (do_eval && grant[i]) begin
                need_d[i] = 1'b0;
                if (active) begin
                    dstat_d[i] = 1'b0;
                    if (cfg_level[i]) rirr_d[i] = 1'b1;
                    else              pend_d[i] = 1'b0;
                end
            end
            if (rise[i] && (cfg_level[i] || !cfg_mask[i])) begin
                pend_d[i]  = 1'b1;
                need_d[i]  = 1'b1;
                dstat_d[i] = 1'b1;
            end
            if (cfg_wr[i]) need_d[i] = 1'b1;
            if (eoi_valid && rirr_q[i]
                && cfg_vector[i*VEC_W +: VEC_W] == eoi_vector) begin
                rirr_d[i] = 1'b0;
                need_d[i] = 1'b1;
            end
            if (fall[i] && cfg_level[i]) pend_d[i] = 1'b0;
        end
    end

    // Per-line state registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            need_q  <= '0;
            pend_q  <= '0;
            rirr_q  <= '0;
            dstat_q <= '0;
        end else begin
            need_q  <= need_d;
            pend_q  <= pend_d;
            rirr_q  <= rirr_d;
            dstat_q <= dstat_d;
        end
    end

    irq_msg_slot i_slot (
        .clk(clk), .rst_n(rst_n), .load(send), .load_msg(new_msg),
        .ready(msg_ready), .valid(msg_valid), .msg(out_msg)
    );

    assign msg_vector       = out_msg.vector;
    assign msg_mode         = out_msg.mode;
    assign msg_level        = out_msg.level;
    assign msg_dest         = out_msg.dest;
    assign msg_dest_logical = out_msg.dest_logical;
    assign pend_o  = pend_q;
    assign rirr_o  = rirr_q;
    assign dstat_o = dstat_q;

    // R8: only fixed or lowest-priority messages leave the block.
    p_mode_legal_r8: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> (msg_mode == MODE_FIXED || msg_mode == MODE_LOWPRI));

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line_chk
        // R6: a falling level-triggered line leaves nothing pending.
        p_fall_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
            fall[g] && cfg_level[g] |=> !pend_q[g]);
        // R2: a masked edge-triggered rise is not recorded.
        p_masked_edge_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
            rise[g] && !cfg_level[g] && cfg_mask[g] && !pend_q[g] |=> !pend_q[g]);
        // R7: a matching end-of-interrupt releases the lockout.
        p_eoi_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
            eoi_valid && rirr_q[g] && cfg_vector[g*VEC_W +: VEC_W] == eoi_vector
            |=> !rirr_q[g]);
    end
endmodule

// File: tb/test_irq_route_engine.sv
module test_irq_route_engine;
    localparam int N = 24;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  irq_in = '0;
    logic [N*8-1:0] cfg_vector = '0;
    logic [N*3-1:0] cfg_mode = '0;
    logic [N-1:0]  cfg_dest_logical = '0;
    logic [N-1:0]  cfg_level = '0;
    logic [N-1:0]  cfg_mask = '1;
    logic [N*DW-1:0] cfg_dest_word = '0;
    logic [N-1:0]  cfg_wr = '0;
    logic          eoi_valid = 1'b0;
    logic [7:0]    eoi_vector = '0;
    logic          msg_valid;
    logic          msg_ready = 1'b0;
    logic [7:0]    msg_vector;
    logic [2:0]    msg_mode;
    logic          msg_level;
    logic [7:0]    msg_dest;
    logic          msg_dest_logical;
    logic [N-1:0]  pend_o, rirr_o, dstat_o;

    int n_checks = 0;
    int n_fail = 0;

    irq_route_engine #(.NUM_LINES(N), .DWORD_W(DW)) i_irq_route_engine (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .cfg_vector(cfg_vector),
        .cfg_mode(cfg_mode), .cfg_dest_logical(cfg_dest_logical),
        .cfg_level(cfg_level), .cfg_mask(cfg_mask), .cfg_dest_word(cfg_dest_word),
        .cfg_wr(cfg_wr), .eoi_valid(eoi_valid), .eoi_vector(eoi_vector),
        .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_vector(msg_vector),
        .msg_mode(msg_mode), .msg_level(msg_level), .msg_dest(msg_dest),
        .msg_dest_logical(msg_dest_logical), .pend_o(pend_o), .rirr_o(rirr_o),
        .dstat_o(dstat_o)
    );

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic set_entry(input int i, input logic [7:0] vec, input logic [2:0] mode,
                             input logic dlog, input logic lvl, input logic msk,
                             input logic [31:0] dword);
        cfg_vector[i*8 +: 8]  = vec;
        cfg_mode[i*3 +: 3]    = mode;
        cfg_dest_logical[i]   = dlog;
        cfg_level[i]          = lvl;
        cfg_mask[i]           = msk;
        cfg_dest_word[i*DW +: DW] = dword;
    endtask

    task automatic pulse_cfg(input int i);
        @(negedge clk) cfg_wr[i] = 1'b1;
        @(negedge clk) cfg_wr[i] = 1'b0;
    endtask

    task automatic send_eoi(input logic [7:0] v);
        @(negedge clk) begin eoi_valid = 1'b1; eoi_vector = v; end
        @(negedge clk) eoi_valid = 1'b0;
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Wait for a message, check every field, then accept it.
    task automatic expect_msg(input string tag, input logic [7:0] vec,
                              input logic [2:0] mode, input logic lvl,
                              input logic [7:0] dest, input logic dlog);
        bit seen = 1'b0;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            if (msg_valid) begin seen = 1'b1; break; end
        end
        check(seen, {tag, " valid"}, 32'(msg_valid), 32'd1);
        if (seen) begin
            check(msg_vector == vec, {tag, " vector"}, 32'(msg_vector), 32'(vec));
            check(msg_mode == mode, {tag, " mode"}, 32'(msg_mode), 32'(mode));
            check(msg_level == lvl, {tag, " level"}, 32'(msg_level), 32'(lvl));
            check(msg_dest == dest, {tag, " dest"}, 32'(msg_dest), 32'(dest));
            check(msg_dest_logical == dlog, {tag, " dlog"},
                  32'(msg_dest_logical), 32'(dlog));
            msg_ready = 1'b1;
            @(negedge clk) msg_ready = 1'b0;
        end
    endtask

    task automatic expect_none(input string tag, input int n);
        bit bad = 1'b0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (msg_valid) bad = 1'b1;
        end
        check(!bad, tag, 32'(msg_valid), 32'd0);
        if (msg_valid) begin
            msg_ready = 1'b1;
            @(negedge clk) msg_ready = 1'b0;
        end
    endtask

    task automatic t_reset();
        check(!msg_valid, "R4 reset valid", 32'(msg_valid), 0);
        check(pend_o == 0 && rirr_o == 0 && dstat_o == 0, "R4 reset flags",
              32'(pend_o | rirr_o | dstat_o), 0);
    endtask

    task automatic t_edge();
        set_entry(3, 8'h33, 3'd1, 1'b1, 1'b0, 1'b0, 32'hA512_3456);
        @(negedge clk) irq_in[3] = 1'b1;
        expect_msg("R4 R9 edge", 8'h33, 3'd1, 1'b0, 8'hA5, 1'b1);
        check(!pend_o[3], "R4 pending cleared", 32'(pend_o[3]), 0);
        expect_none("R1 held high", 12);
        @(negedge clk) irq_in[3] = 1'b0;
        cycles(2);
        @(negedge clk) irq_in[3] = 1'b1;
        expect_msg("R1 second rise", 8'h33, 3'd1, 1'b0, 8'hA5, 1'b1);
        @(negedge clk) irq_in[3] = 1'b0;
    endtask

    task automatic t_masked_edge();
        set_entry(5, 8'h45, 3'd0, 1'b0, 1'b0, 1'b1, 32'h0100_0000);
        @(negedge clk) irq_in[5] = 1'b1;
        cycles(3);
        check(!pend_o[5], "R2 masked edge pending", 32'(pend_o[5]), 0);
        cfg_mask[5] = 1'b0;
        pulse_cfg(5);
        expect_none("R2 unmask after drop", 8);
        @(negedge clk) irq_in[5] = 1'b0;
    endtask

    task automatic t_masked_level();
        set_entry(6, 8'h46, 3'd0, 1'b0, 1'b1, 1'b1, 32'h0700_0000);
        @(negedge clk) irq_in[6] = 1'b1;
        cycles(3);
        check(pend_o[6], "R3 masked level pending", 32'(pend_o[6]), 1);
        check(dstat_o[6], "R3 delivery status", 32'(dstat_o[6]), 1);
        expect_none("R3 held while masked", 6);
        cfg_mask[6] = 1'b0;
        pulse_cfg(6);
        expect_msg("R12 unmask delivers", 8'h46, 3'd0, 1'b1, 8'h07, 1'b0);
        check(rirr_o[6], "R5 lockout set", 32'(rirr_o[6]), 1);
        check(!dstat_o[6], "R3 status cleared", 32'(dstat_o[6]), 0);
    endtask

    task automatic t_lockout();
        pulse_cfg(6);
        expect_none("R5 lockout blocks", 8);
        send_eoi(8'h99);
        expect_none("R7 other vector", 6);
        check(rirr_o[6], "R7 other vector keeps lockout", 32'(rirr_o[6]), 1);
        send_eoi(8'h46);
        expect_msg("R7 eoi redelivers", 8'h46, 3'd0, 1'b1, 8'h07, 1'b0);
        @(negedge clk) irq_in[6] = 1'b0;
        cycles(2);
        check(!pend_o[6], "R6 fall clears pending", 32'(pend_o[6]), 0);
        send_eoi(8'h46);
        expect_none("R6 no pending no message", 6);
        check(!rirr_o[6], "R7 lockout released", 32'(rirr_o[6]), 0);
    endtask

    task automatic t_mode_drop();
        set_entry(8, 8'h58, 3'd4, 1'b0, 1'b0, 1'b0, 32'h0200_0000);
        @(negedge clk) irq_in[8] = 1'b1;
        expect_none("R8 mode 4 dropped", 8);
        check(!pend_o[8] && !dstat_o[8], "R8 flags after drop",
              32'({pend_o[8], dstat_o[8]}), 0);
        @(negedge clk) irq_in[8] = 1'b0;
    endtask

    task automatic t_order();
        set_entry(10, 8'h2A, 3'd0, 1'b0, 1'b0, 1'b0, 32'h0A00_0000);
        set_entry(2,  8'h22, 3'd0, 1'b0, 1'b0, 1'b0, 32'h0200_0000);
        @(negedge clk) begin irq_in[10] = 1'b1; irq_in[2] = 1'b1; end
        expect_msg("R10 first lowest", 8'h22, 3'd0, 1'b0, 8'h02, 1'b0);
        expect_msg("R10 then higher", 8'h2A, 3'd0, 1'b0, 8'h0A, 1'b0);
        @(negedge clk) begin irq_in[10] = 1'b0; irq_in[2] = 1'b0; end
    endtask

    task automatic t_hold();
        bit moved = 1'b0;
        set_entry(12, 8'h5C, 3'd1, 1'b1, 1'b0, 1'b0, 32'hC300_0000);
        @(negedge clk) irq_in[12] = 1'b1;
        cycles(3);
        check(msg_valid, "R11 message waiting", 32'(msg_valid), 1);
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            if (!msg_valid || msg_vector != 8'h5C || msg_dest != 8'hC3) moved = 1'b1;
        end
        check(!moved, "R11 held stable", 32'(msg_vector), 32'h5C);
        msg_ready = 1'b1;
        @(negedge clk) msg_ready = 1'b0;
        check(!msg_valid, "R11 released on ready", 32'(msg_valid), 0);
        @(negedge clk) irq_in[12] = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < N; i++)
            set_entry(i, 8'(8'h60 + i), 3'd0, 1'b0, 1'b0, 1'b1, 32'h0);
        cycles(3);
        @(negedge clk) rst_n = 1'b1;
        t_reset();
        t_edge();
        t_masked_edge();
        t_masked_level();
        t_lockout();
        t_mode_drop();
        t_order();
        t_hold();
        cycles(2);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule